// File: doc/BRIEF.md
# Coincidence Channel Matrix

This block sits between four shaped photon-detector pulse lines and an eight-channel counter bank. In every cycle it turns the current detector pattern into eight count-enable bits: the first four repeat the single detector lines, and the last four report coincidences. A coincidence is the AND of the pulses that overlap in that cycle. The detector lines are mapped as bit 0 = A, bit 1 = A', bit 2 = B and bit 3 = B'.

A two-bit mode input selects the channel set. Two modes are fixed: one serves second-order correlation runs and the other serves local-realism tests. A third mode takes four 4-bit masks, and each mask defines one arbitrary 2-, 3- or 4-fold coincidence. The fourth code is reserved and silences all outputs. Mode and masks go through a small two-state configuration machine. In state ST_OPEN, counting is idle, and the machine copies the inputs into shadow registers on each edge. In state ST_LOCKED, counting runs, and the machine holds the shadow copy. Transition START (idle_i low) moves ST_OPEN to ST_LOCKED. Transition STOP (idle_i high) moves ST_LOCKED back to ST_OPEN. An optional output register (parameter REG_OUT, default on) adds one cycle of latency. The coincidence path has no dead time.

Top module: `coinc_matrix`

## Requirements
- R1: In modes 00, 01 and 10, cnt_en_o[0..3] equal det_i[0..3] (A, A', B, B').
- R2: In mode 00 (correlation), cnt_en_o[4..7] are A&B, A&B&B', A&B', B&B'.
- R3: In mode 01 (local realism), cnt_en_o[4..7] are A&B, A'&B, A&B', A'&B'.
- R4: In mode 10 (programmable), cnt_en_o[4+k] is the AND of every det_i[j] whose bit j is set in mask_i[4k+3:4k].
- R5: In mode 10, a mask with fewer than two bits set holds its channel at 0 for every detector pattern.
- R6: Mode 11 drives all eight outputs to 0.
- R7: Mode and masks are captured only on clock edges where idle_i is 1 (ST_OPEN). Changes made while idle_i is 0 have no effect until idle_i returns to 1.
- R8: With REG_OUT=1, cnt_en_o shows the result for the det_i value sampled at the previous edge. Each cycle is evaluated independently, so coincidences on back-to-back cycles are all reported.
- R9: Reset clears cnt_en_o to 0, sets the configuration to mode 00 with all masks zero, and enters ST_OPEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_i | input | 1 | High while counting is idle; enables configuration capture |
| mode_i | input | 2 | Channel-set select: 00 correlation, 01 local realism, 10 programmable, 11 reserved |
| mask_i | input | 16 | Four 4-bit coincidence masks; nibble k drives channel 4+k |
| det_i | input | 4 | Shaped detector pulses: bit0 A, bit1 A', bit2 B, bit3 B' |
| cnt_en_o | output | 8 | Count enables for the counter bank |

## Verification
The bench drives all sixteen detector patterns through each mode, so a channel wired to the wrong input or to the other fixed set shows up as a miscount on a specific pattern. Masks with zero or one bit set are applied on purpose, because a design without the fewer-than-two guard would pass plain singles into a coincidence channel. The bench changes the mode while counting is locked, so a design that ignores idle_i switches channel sets mid-run. Alternating patterns on consecutive cycles would expose any hold-off or off-by-one latency as dropped or shifted coincidences.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
    localparam int NDET  = 4;
    localparam int NPROG = 4;
    localparam int NCH   = NDET + NPROG;
    localparam int MASKW = NDET * NPROG;

    typedef enum logic [1:0] {
        MODE_CORR = 2'b00,
        MODE_BELL = 2'b01,
        MODE_PROG = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } cfg_st_e;

    typedef logic [NDET-1:0] sel_t;

    // detector bit order: 0=A 1=A' 2=B 3=B'
    function automatic sel_t corr_sel(input int k);
        case (k)
            0:       return 4'b0101;  // A B
            1:       return 4'b1101;  // A B B'
            2:       return 4'b1001;  // A B'
            default: return 4'b1100;  // B B'
        endcase
    endfunction

    function automatic sel_t bell_sel(input int k);
        case (k)
            0:       return 4'b0101;  // A B
            1:       return 4'b0110;  // A' B
            2:       return 4'b1001;  // A B'
            default: return 4'b1010;  // A' B'
        endcase
    endfunction
endpackage

// File: rtl/coinc_cfg_fsm.sv
module coinc_cfg_fsm
    import coinc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic [1:0]       mode_i,
    input  logic [MASKW-1:0] mask_i,
    output mode_e            mode_q,
    output logic [MASKW-1:0] mask_q,
    output cfg_st_e          state_q
);
    cfg_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (!idle_i) state_d = ST_LOCKED;  // START
            ST_LOCKED: if (idle_i)  state_d = ST_OPEN;    // STOP
            default:   state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_CORR;
            mask_q <= '0;
        end else if (idle_i) begin
            mode_q <= mode_e'(mode_i);
            mask_q <= mask_i;
        end
    end
endmodule

// File: rtl/coinc_nfold.sv
module coinc_nfold #(
    parameter int W = 4
) (
    input  logic [W-1:0] det_i,
    input  logic [W-1:0] sel_i,
    output logic         hit_o
);
    logic [$clog2(W+1)-1:0] nsel;

    always_comb begin
        nsel = '0;
        for (int j = 0; j < W; j++) nsel = nsel + {{($clog2(W+1)-1){1'b0}}, sel_i[j]};
    end

    assign hit_o = (nsel >= 2) && ((det_i & sel_i) == sel_i);
endmodule

// File: rtl/coinc_matrix.sv
module coinc_matrix
    import coinc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic [1:0]       mode_i,
    input  logic [MASKW-1:0] mask_i,
    input  logic [NDET-1:0]  det_i,
    output logic [NCH-1:0]   cnt_en_o
);
    mode_e            cfg_mode;
    logic [MASKW-1:0] cfg_mask;
    cfg_st_e          cfg_state;
    logic [NCH-1:0]   en_c;

    coinc_cfg_fsm u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle_i  (idle_i),
        .mode_i  (mode_i),
        .mask_i  (mask_i),
        .mode_q  (cfg_mode),
        .mask_q  (cfg_mask),
        .state_q (cfg_state)
    );

    assign en_c[NDET-1:0] = (cfg_mode == MODE_RSVD) ? '0 : det_i;

    for (genvar k = 0; k < NPROG; k++) begin : g_chan
        sel_t sel;
        always_comb begin
            unique case (cfg_mode)
                MODE_CORR: sel = corr_sel(k);
                MODE_BELL: sel = bell_sel(k);
                MODE_PROG: sel = cfg_mask[k*NDET +: NDET];
                default:   sel = '0;
            endcase
        end
        coinc_nfold #(.W(NDET)) u_and (
            .det_i (det_i),
            .sel_i (sel),
            .hit_o (en_c[NDET+k])
        );
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_en_o <= '0;
            else        cnt_en_o <= en_c;
        end
    end else begin : g_comb
        assign cnt_en_o = en_c;
    end
endmodule

// File: rtl/coinc_matrix_chk.sv
module coinc_matrix_chk
    import coinc_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_i,
    input logic [NDET-1:0]  det_i,
    input logic [NCH-1:0]   cnt_en_o,
    input mode_e            cfg_mode,
    input logic [MASKW-1:0] cfg_mask,
    input cfg_st_e          cfg_state
);
    if (REG_OUT) begin : g_chk
        // R1
        singles_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode != MODE_RSVD) |=> (cnt_en_o[NDET-1:0] == $past(det_i)));
        // R6
        rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_mode == MODE_RSVD) |=> (cnt_en_o == '0));
        // R5
        coinc_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_en_o[NCH-1:NDET] != '0) |-> ($countones($past(det_i)) >= 2));
        // R2
        all_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((cfg_mode == MODE_CORR || cfg_mode == MODE_BELL) && det_i == '1) |=> (cnt_en_o == '1));
    end
    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> ($stable(cfg_mode) && $stable(cfg_mask)));
    // R7
    locked_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> (cfg_state == ST_LOCKED));
    // R9
    open_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (cfg_state == ST_OPEN));
endmodule

bind coinc_matrix coinc_matrix_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle_i),
    .det_i     (det_i),
    .cnt_en_o  (cnt_en_o),
    .cfg_mode  (cfg_mode),
    .cfg_mask  (cfg_mask),
    .cfg_state (cfg_state)
);

// File: tb/sim_coinc_matrix.sv
`timescale 1ns/1ps
module sim_coinc_matrix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle_i = 1'b1;
    logic [1:0]  mode_i = 2'b00;
    logic [15:0] mask_i = '0;
    logic [3:0]  det_i = '0;
    logic [7:0]  cnt_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    coinc_matrix u0 (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .mode_i(mode_i),
        .mask_i(mask_i), .det_i(det_i), .cnt_en_o(cnt_en_o)
    );

    function automatic logic [7:0] model(input logic [1:0] m, input logic [15:0] mk, input logic [3:0] d);
        logic a, ap, b, bp;
        logic [7:0] r;
        a = d[0]; ap = d[1]; b = d[2]; bp = d[3];
        r = {4'b0, d};
        case (m)
            2'b00: r[7:4] = {b & bp, a & bp, a & b & bp, a & b};
            2'b01: r[7:4] = {ap & bp, a & bp, ap & b, a & b};
            2'b10: for (int k = 0; k < 4; k++) begin
                       logic [3:0] s;
                       s = mk[4*k +: 4];
                       r[4+k] = ($countones(s) >= 2) && ((d & s) == s);
                   end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input logic [7:0] exp, input string tag);
        n_chk++;
        if (cnt_en_o !== exp) begin
            n_bad++;
            $display("FAIL %s det=%b actual=%b expected=%b", tag, det_i, cnt_en_o, exp);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic apply(input logic [3:0] d, input logic [7:0] exp, input string tag);
        det_i = d;
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic configure(input logic [1:0] m, input logic [15:0] mk);
        idle_i = 1'b1; mode_i = m; mask_i = mk;
        @(negedge clk);
        idle_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(8'h00, "R9 reset output");
        rst_n = 1'b1;
        idle_i = 1'b0;
        apply(4'hF, 8'hFF, "R9 default mode 00");
        apply(4'h5, 8'h15, "R9 default mode 00 AB");
    endtask

    task automatic t_sweep(input logic [1:0] m, input logic [15:0] mk, input string tag);
        configure(m, mk);
        for (int d = 0; d < 16; d++) apply(4'(d), model(m, mk, 4'(d)), tag);
    endtask

    task automatic t_lock();
        configure(2'b00, 16'h0);
        mode_i = 2'b11; mask_i = 16'hFFFF;
        apply(4'hF, 8'hFF, "R7 locked ignores mode 11");
        apply(4'h3, model(2'b00, 0, 4'h3), "R7 locked ignores mode 11");
        configure(2'b11, 16'h0);
        apply(4'hF, 8'h00, "R7 idle capture of mode 11");
    endtask

    task automatic t_burst();
        logic [3:0] pat [6] = '{4'hF, 4'h0, 4'hF, 4'h5, 4'hA, 4'hF};
        configure(2'b01, 16'h0);
        for (int i = 0; i < 6; i++) apply(pat[i], model(2'b01, 0, pat[i]), "R8 back-to-back");
    endtask

    initial begin
        t_reset();
        t_sweep(2'b00, 16'h0, "R1 R2 correlation");
        t_sweep(2'b01, 16'h0, "R1 R3 local realism");
        t_sweep(2'b10, 16'hF_B_3_5, "R4 programmable 2/3/4-fold");
        t_sweep(2'b10, 16'hA_7_C_6, "R4 programmable mixed");
        t_sweep(2'b10, 16'h8_4_1_0, "R5 short masks");
        t_sweep(2'b11, 16'hFFFF, "R6 reserved");
        t_lock();
        t_burst();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8ns * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule